// File: doc/BRIEF.md
# Stepped-Frequency Multi-Channel PWM Generator

This block drives a set of PWM output pins, four by default. Each pin has its own 8-bit frequency code and 8-bit duty code. Three shared 8-bit control words are common to all channels: a global mode word, a polarity word and an enable word. The frequency code picks one of four coarse ranges, whose base rates are spaced by a factor of four. A 6-bit multiplier then scales that base rate. The result covers 0.5 Hz up to 2048 Hz in steps that get coarser as the frequency rises.

A prescaled tick input drives every channel. Each channel feeds the tick into a phase accumulator. Every accumulator wrap moves the channel on by one of 256 duty slots, and 256 slots make one PWM period. The tick must run at 256 × 2048 Hz (524288 Hz) for the code to map to the nominal frequencies.

The configuration inputs act on the outputs at once. Changing them never resets or realigns the counters, so a change in the middle of a period can produce one period that matches neither the old setting nor the new one.

Top module: `spwm_gen`

## Requirements
- R1: Frequency code bits 7:6 hold the range step S and bits 5:0 hold the multiplier M. On every tick the channel adds (M+1)·4^S to a 12-bit accumulator. Each carry out of the accumulator advances the duty slot by one. One period is 256 slots, which lasts 256·4096/((M+1)·4^S) ticks.
- R2: Within each period the output is at its active level while the slot number is at most the duty code D, which gives D+1 of 256 slots. D=0 gives one slot and D=255 keeps the output active for the whole period. A 0% duty cannot be expressed.
- R3: Channel c (numbered 1 to 4) inverts its active level when bit c+1 of the polarity word is set (bits 2..5). No other bit of the polarity word affects any channel.
- R4: Channel c is enabled by bit 4+c−1 of the enable word (bits 4..7). A disabled channel drives a constant low, whatever its polarity setting.
- R5: Every output is held low unless bits 7:6 of the global mode word equal 01. The lower six bits of that word have no effect.
- R6: A change to frequency, duty or polarity shows on the output in the same cycle. The change does not clear or realign the slot counter, which keeps counting from where it was.
- R7: The counters move only on cycles where the tick is high. While the tick is low, every output holds its value.
- R8: Reset clears the accumulators and slot counters. When reset is released, every channel therefore starts at slot 0, which is within its active window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick; the accumulators advance on cycles where it is high |
| glb_ctrl_i | input | 8 | Global mode word; bits 7:6 = 01 selects normal operation |
| pol_ctrl_i | input | 8 | Polarity word; bit c+1 inverts channel c |
| en_ctrl_i | input | 8 | Enable word; bit 4+c−1 enables channel c |
| freq_codes_i | input | NCH·8 | Frequency codes, channel 1 in the lowest byte |
| duty_codes_i | input | NCH·8 | Duty codes, channel 1 in the lowest byte |
| pwm_o | output | NCH | PWM outputs, channel 1 in bit 0 |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit codes and a 12-bit accumulator. It holds the tick high on every clock, so the step-3 ranges advance a slot every one to a few clocks. This puts full periods of 256 to 16384 clocks within reach, and the bench measures the active time over exactly one period using codes whose increment divides 4096. Live updates and tick gating are checked against a known slot position. That position is found from the single-slot pulse that a duty code of zero produces.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam int FREQ_W = 8;
  localparam int STEP_W = 2;
  localparam int MULT_W = FREQ_W - STEP_W;
  localparam int DUTY_W = 8;
  localparam int SLOT_W = 8;
  // Largest increment is 2^MULT_W * 4^(2^STEP_W - 1); the accumulator spans it.
  localparam int ACC_W  = MULT_W + 2 * ((1 << STEP_W) - 1);

  localparam logic [1:0] MODE_NORMAL = 2'b01;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [DUTY_W-1:0] duty;
    logic              inv;
    logic              en;
  } chan_cfg_t;

  // Accumulator increment per tick: (mult + 1) * 4^step.
  function automatic logic [ACC_W:0] freq_inc(input logic [FREQ_W-1:0] code);
    logic [ACC_W:0]      mult_p1;
    logic [STEP_W-1:0]   step;
    mult_p1 = (ACC_W + 1)'(code[MULT_W-1:0]) + (ACC_W + 1)'(1);
    step    = code[FREQ_W-1 -: STEP_W];
    return mult_p1 << {step, 1'b0};
  endfunction

  // A slot is inside the active window when it does not exceed the duty code.
  function automatic logic slot_active(input logic [SLOT_W-1:0] slot,
                                       input logic [DUTY_W-1:0] duty);
    return slot <= duty;
  endfunction

endpackage

// File: rtl/spwm_chan_timer.sv
module spwm_chan_timer
  import spwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [FREQ_W-1:0] freq_code_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_adv_o
);

  logic [ACC_W-1:0]  acc_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ACC_W:0]    inc;
  logic [ACC_W:0]    sum;
  logic              carry;

  assign inc        = freq_inc(freq_code_i);
  assign sum        = {1'b0, acc_q} + inc;
  assign carry      = sum[ACC_W];
  assign slot_adv_o = tick_i & carry;
  assign slot_o     = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
    end else if (tick_i) begin
      acc_q <= sum[ACC_W-1:0];
      if (carry) slot_q <= slot_q + SLOT_W'(1);
    end
  end

  AST_SLOT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_q) |-> slot_q == $past(slot_q) + SLOT_W'(1)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(slot_q) && $stable(acc_q))); // R7

endmodule

// File: rtl/spwm_out_stage.sv
module spwm_out_stage
  import spwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              inv_i,
  input  logic              en_i,
  input  logic              mode_ok_i,
  output logic              pwm_o
);

  logic in_window;
  logic drive_ok;

  assign in_window = slot_active(slot_i, duty_i);
  assign drive_ok  = en_i & mode_ok_i;
  // Gating sits outside the inversion, so a disabled pin is low either way.
  assign pwm_o     = drive_ok & (in_window ^ inv_i);

  AST_SLOT0_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ok && slot_i == '0) |-> pwm_o == !inv_i); // R2

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_o); // R4

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int REG_W   = 8,
  parameter int POL_LSB = 2,
  parameter int EN_LSB  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [REG_W-1:0]      glb_ctrl_i,
  input  logic [REG_W-1:0]      pol_ctrl_i,
  input  logic [REG_W-1:0]      en_ctrl_i,
  input  logic [NCH*FREQ_W-1:0] freq_codes_i,
  input  logic [NCH*DUTY_W-1:0] duty_codes_i,
  output logic [NCH-1:0]        pwm_o
);

  localparam int MODE_MSB = REG_W - 1;

  logic           mode_ok;
  logic [NCH-1:0] slot_adv;
  logic           unused_bits;

  assign mode_ok     = (glb_ctrl_i[MODE_MSB -: 2] == MODE_NORMAL);
  assign unused_bits = ^{glb_ctrl_i, pol_ctrl_i, en_ctrl_i, slot_adv};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    chan_cfg_t         cfg;
    logic [SLOT_W-1:0] slot;

    assign cfg.freq = freq_codes_i[ch*FREQ_W +: FREQ_W];
    assign cfg.duty = duty_codes_i[ch*DUTY_W +: DUTY_W];
    assign cfg.inv  = pol_ctrl_i[POL_LSB + ch];
    assign cfg.en   = en_ctrl_i[EN_LSB + ch];

    spwm_chan_timer u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .freq_code_i (cfg.freq),
      .slot_o      (slot),
      .slot_adv_o  (slot_adv[ch])
    );

    spwm_out_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_i    (slot),
      .duty_i    (cfg.duty),
      .inv_i     (cfg.inv),
      .en_i      (cfg.en),
      .mode_ok_i (mode_ok),
      .pwm_o     (pwm_o[ch])
    );
  end

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_ctrl_i[MODE_MSB -: 2] != MODE_NORMAL) |-> pwm_o == '0); // R5

endmodule

// File: tb/spwm_gen_tb.sv
module spwm_gen_tb;

  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick_i = 1'b1;
  logic [7:0]      glb_ctrl = '0;
  logic [7:0]      pol_ctrl = '0;
  logic [7:0]      en_ctrl = '0;
  logic [NCH*8-1:0] freq_codes = '0;
  logic [NCH*8-1:0] duty_codes = '0;
  logic [NCH-1:0]  pwm_o;

  int checks = 0;
  int errors = 0;

  spwm_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .glb_ctrl_i   (glb_ctrl),
    .pol_ctrl_i   (pol_ctrl),
    .en_ctrl_i    (en_ctrl),
    .freq_codes_i (freq_codes),
    .duty_codes_i (duty_codes),
    .pwm_o        (pwm_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  step;
    logic [5:0]  mult;
    logic [7:0]  duty;
    logic        inv;
    int unsigned period;
    int unsigned high;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd3, 6'd63, 8'd0,   1'b0, 256,   1},
    '{2'd1, 2'd3, 6'd63, 8'd255, 1'b0, 256,   256},
    '{2'd2, 2'd3, 6'd31, 8'd127, 1'b0, 512,   256},
    '{2'd3, 2'd2, 6'd63, 8'd63,  1'b0, 1024,  256},
    '{2'd0, 2'd3, 6'd15, 8'd3,   1'b1, 1024,  1008},
    '{2'd1, 2'd1, 6'd63, 8'd0,   1'b0, 4096,  16},
    '{2'd2, 2'd3, 6'd0,  8'd9,   1'b0, 16384, 640}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_chan(input int ch, input logic [1:0] st,
                          input logic [5:0] mu, input logic [7:0] du);
    freq_codes[ch*8 +: 8] = {st, mu};
    duty_codes[ch*8 +: 8] = du;
  endtask

  task automatic count_high(input int ch, input int n, output int hi, output int others);
    hi = 0;
    others = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
      for (int c = 0; c < NCH; c++)
        if (c != ch && pwm_o[c]) others++;
    end
  endtask

  task automatic wait_rise(input int ch);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (pwm_o[ch] !== 1'b1 && guard < 100000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, oth, n;

    // Reset state with all-zero configuration
    repeat (2) @(negedge clk);
    chk("R8 outputs low under zero config", int'(pwm_o), 0);

    // R8: counters at slot 0 while reset is held; slot 1 one tick after release
    glb_ctrl = 8'h40;
    en_ctrl  = 8'h10;
    set_chan(0, 2'd3, 6'd63, 8'd0);
    #1;
    chk("R8 slot 0 active during reset", int'(pwm_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 first tick after release leaves window", int'(pwm_o[0]), 0);

    // Table: R1 period/frequency mapping, R2 duty, R3 inversion, R4 others off
    for (int i = 0; i < NVEC; i++) begin
      glb_ctrl = 8'h40;
      en_ctrl  = 8'(1 << (4 + int'(VECS[i].ch)));
      pol_ctrl = VECS[i].inv ? 8'(1 << (2 + int'(VECS[i].ch))) : 8'h00;
      set_chan(int'(VECS[i].ch), VECS[i].step, VECS[i].mult, VECS[i].duty);
      count_high(int'(VECS[i].ch), int'(VECS[i].period), hi, oth);
      chk($sformatf("R1 R2 R3 vector %0d high time", i), hi, int'(VECS[i].high));
      chk($sformatf("R4 vector %0d disabled channels low", i), oth, 0);
    end

    // R5: mode field gating
    pol_ctrl = 8'h00;
    en_ctrl  = 8'h10;
    set_chan(0, 2'd3, 6'd63, 8'd255);
    glb_ctrl = 8'h80;
    count_high(0, 256, hi, oth);
    chk("R5 mode 10 forces low", hi, 0);
    glb_ctrl = 8'hC0;
    count_high(0, 256, hi, oth);
    chk("R5 mode 11 forces low", hi, 0);
    glb_ctrl = 8'h00;
    count_high(0, 256, hi, oth);
    chk("R5 mode 00 forces low", hi, 0);
    glb_ctrl = 8'h7F;
    count_high(0, 256, hi, oth);
    chk("R5 low bits ignored in normal mode", hi, 256);

    // R4: disabled overrides inversion; enable bit positions
    glb_ctrl = 8'h40;
    pol_ctrl = 8'h04;
    en_ctrl  = 8'h00;
    set_chan(0, 2'd3, 6'd63, 8'd0);
    count_high(0, 256, hi, oth);
    chk("R4 disabled inverted channel stays low", hi + oth, 0);
    pol_ctrl = 8'h00;
    for (int c = 0; c < NCH; c++) set_chan(c, 2'd3, 6'd63, 8'd255);
    en_ctrl = 8'h0F;
    count_high(0, 256, hi, oth);
    chk("R4 bits 3:0 enable nothing", hi + oth, 0);
    en_ctrl = 8'h20;
    count_high(1, 256, hi, oth);
    chk("R4 bit 5 enables channel 2", hi, 256);
    chk("R4 bit 5 leaves others low", oth, 0);

    // R3: polarity bit positions
    en_ctrl  = 8'hF0;
    pol_ctrl = 8'h08;
    #1;
    chk("R3 bit 3 inverts channel 2 only", int'(pwm_o), 4'b1101);
    pol_ctrl = 8'hC3;
    #1;
    chk("R3 bits outside 5:2 ignored", int'(pwm_o), 4'b1111);

    // R6: live duty change keeps the running slot count
    pol_ctrl = 8'h00;
    en_ctrl  = 8'h10;
    set_chan(0, 2'd3, 6'd63, 8'd0);
    wait_rise(0);
    repeat (100) @(negedge clk);
    duty_codes[7:0] = 8'd50;
    #1;
    chk("R6 duty change applies at once from slot 100", int'(pwm_o[0]), 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pwm_o[0] == 1'b0 && n < 1000);
    chk("R6 counter not reset by update", n, 156);
    repeat (10) @(negedge clk);
    pol_ctrl = 8'h04;
    #1;
    chk("R6 polarity change applies at once", int'(pwm_o[0]), 0);

    // R7: tick low freezes the counters
    pol_ctrl = 8'h00;
    duty_codes[7:0] = 8'd0;
    wait_rise(0);
    tick_i = 1'b0;
    count_high(0, 300, hi, oth);
    chk("R7 output held with tick low", hi, 300);
    tick_i = 1'b1;
    @(negedge clk);
    chk("R7 counting resumes with tick", int'(pwm_o[0]), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule